// File: doc/BRIEF.md
# Data Fault Capture Register Block

This block keeps a snapshot of the first data access that faults, so that a trap handler can inspect it later. When a fault strobe arrives, the block records three things. The first is the full virtual address. The second is a packed status word made from the opcode of the faulting instruction, its destination register number and six fault flags. The third is a formatted address that points at the page-table entry for the faulting page. It forms that address by OR-ing a page-table base value with the virtual page number shifted up by three.

After a capture the block holds its contents and ignores later faults. Software releases it by reading the address register, which the surrounding logic signals with a one-cycle read strobe. Faults raised on a misspeculated path never touch the registers. All captured values, and the lock, appear at the outputs one clock edge after the cycle that caused them.

Top module: `fault_capture_regs`

## Requirements
- R1: The status output packs the opcode in bits 16:11, the destination register number in bits 10:6 and the six flag bits in bits 5:0, all taken from the capturing cycle.
- R2: Each flag input bit lands unchanged in the same status bit: bit 0 write, bit 1 access violation, bit 2 fault-on-read, bit 3 fault-on-write, bit 4 bad virtual address, bit 5 translation miss.
- R3: On a capture, the address output takes the full faulting virtual address.
- R4: On a capture, the formatted output becomes the base input OR ((virtual address >> 13) << 3), truncated to the address width.
- R5: A fault strobe with the misspeculation input high changes no register and leaves the lock clear.
- R6: A capture sets the lock on the same edge that loads the registers. While the lock is set, fault strobes change no register.
- R7: A read strobe clears the lock on the next edge and leaves all three registers unchanged.
- R8: A fault strobe in the same cycle as a read strobe is not captured, whether or not the lock was set.
- R9: Synchronous reset clears the three registers and the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_stb | input | 1 | A data access faulted this cycle |
| fault_va | input | VA_W | Virtual address of the faulting access |
| fault_opc | input | 6 | Opcode of the faulting instruction |
| fault_dreg | input | 5 | Destination register number |
| fault_flags | input | 6 | Fault flag bits (see R2) |
| pt_base | input | VA_W | Page-table base value |
| misspec | input | 1 | Current access is on a misspeculated path |
| va_rd | input | 1 | Software reads the address register this cycle |
| va_q | output | VA_W | Captured virtual address |
| stat_q | output | 17 | Captured status word |
| form_q | output | VA_W | Captured page-table entry address |
| locked | output | 1 | Registers are frozen until the next read |

## Verification
The assertions assume that the inputs carry known values from the first cycle of reset onward. In particular, misspeculation and the read strobe are never unknown, because the checks on register stability and on the lock's rise look one cycle back into those inputs. The bench drives every input on the falling edge, and it holds the strobes low during reset and between operations. The mix of stimulus covers read-with-fault, fault-while-locked and misspeculated faults. It never leaves an input undriven, so each past-value check sees only defined levels.

// File: rtl/fcr_pkg.sv
package fcr_pkg;

    localparam int OPC_W  = 6;
    localparam int REG_W  = 5;
    localparam int FLG_W  = 6;
    localparam int STAT_W = OPC_W + REG_W + FLG_W;

    // Flag bits, most significant first so that "wr" sits in bit 0.
    typedef struct packed {
        logic miss;
        logic bad_va;
        logic fo_wr;
        logic fo_rd;
        logic acv;
        logic wr;
    } flt_flags_t;

    typedef struct packed {
        logic [OPC_W-1:0] opc;
        logic [REG_W-1:0] dreg;
        flt_flags_t       flg;
    } flt_stat_t;

    typedef enum logic {
        LK_OPEN = 1'b0,
        LK_HELD = 1'b1
    } lock_state_e;

    function automatic flt_stat_t pack_status(
        input logic [OPC_W-1:0] opc,
        input logic [REG_W-1:0] dreg,
        input logic [FLG_W-1:0] flg
    );
        flt_stat_t s;
        s.opc  = opc;
        s.dreg = dreg;
        s.flg  = flt_flags_t'(flg);
        return s;
    endfunction

endpackage

// File: rtl/fcr_status_pack.sv
module fcr_status_pack
    import fcr_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    input  logic [REG_W-1:0] dreg,
    input  logic [FLG_W-1:0] flags,
    output flt_stat_t        stat
);

    always_comb begin
        stat = pack_status(opc, dreg, flags);
    end

endmodule

// File: rtl/fcr_vpte_form.sv
module fcr_vpte_form #(
    parameter int VA_W       = 64,
    parameter int PAGE_SHIFT = 13,
    parameter int PTE_SHIFT  = 3
) (
    input  logic [VA_W-1:0] va,
    input  logic [VA_W-1:0] base,
    output logic [VA_W-1:0] form
);

    localparam int VPN_W = VA_W - PAGE_SHIFT;

    logic [VPN_W-1:0] vpn;

    always_comb begin
        vpn  = va[VA_W-1:PAGE_SHIFT];
        form = base | (VA_W'(vpn) << PTE_SHIFT);
    end

endmodule

// File: rtl/fcr_lock_ctrl.sv
module fcr_lock_ctrl
    import fcr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fault_stb,
    input  logic misspec,
    input  logic va_rd,
    output logic capture,
    output logic locked
);

    lock_state_e state_q;
    lock_state_e state_d;

    always_comb begin
        capture = fault_stb && !misspec && !va_rd && (state_q == LK_OPEN);
        state_d = state_q;
        if (va_rd) begin
            state_d = LK_OPEN;
        end else if (capture) begin
            state_d = LK_HELD;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LK_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    assign locked = (state_q == LK_HELD);

    // A read always releases the lock on the next edge.
    assert_read_unlocks_R7: assert property (@(posedge clk) disable iff (rst)
        va_rd |=> !locked);

    // The lock only rises after a genuine fault with no read alongside it.
    assert_lock_cause_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(fault_stb && !misspec && !va_rd));

    // A misspeculated fault never sets the lock from the open state.
    assert_misspec_no_lock_R5: assert property (@(posedge clk) disable iff (rst)
        (misspec && !locked) |=> !locked);

endmodule

// File: rtl/fault_capture_regs.sv
module fault_capture_regs
    import fcr_pkg::*;
#(
    parameter int VA_W       = 64,
    parameter int PAGE_SHIFT = 13,
    parameter int PTE_SHIFT  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fault_stb,
    input  logic [VA_W-1:0]   fault_va,
    input  logic [OPC_W-1:0]  fault_opc,
    input  logic [REG_W-1:0]  fault_dreg,
    input  logic [FLG_W-1:0]  fault_flags,
    input  logic [VA_W-1:0]   pt_base,
    input  logic              misspec,
    input  logic              va_rd,
    output logic [VA_W-1:0]   va_q,
    output logic [STAT_W-1:0] stat_q,
    output logic [VA_W-1:0]   form_q,
    output logic              locked
);

    flt_stat_t        stat_d;
    flt_stat_t        stat_r;
    logic [VA_W-1:0]  form_d;
    logic [VA_W-1:0]  va_r;
    logic [VA_W-1:0]  form_r;
    logic             capture;

    fcr_status_pack u_pack (
        .opc   (fault_opc),
        .dreg  (fault_dreg),
        .flags (fault_flags),
        .stat  (stat_d)
    );

    fcr_vpte_form #(
        .VA_W       (VA_W),
        .PAGE_SHIFT (PAGE_SHIFT),
        .PTE_SHIFT  (PTE_SHIFT)
    ) u_form (
        .va   (fault_va),
        .base (pt_base),
        .form (form_d)
    );

    fcr_lock_ctrl u_lock (
        .clk       (clk),
        .rst       (rst),
        .fault_stb (fault_stb),
        .misspec   (misspec),
        .va_rd     (va_rd),
        .capture   (capture),
        .locked    (locked)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            va_r   <= '0;
            stat_r <= '0;
            form_r <= '0;
        end else if (capture) begin
            va_r   <= fault_va;
            stat_r <= stat_d;
            form_r <= form_d;
        end
    end

    assign va_q   = va_r;
    assign stat_q = stat_r;
    assign form_q = form_r;

    // While frozen and not being read, nothing moves.
    assert_hold_when_locked_R6: assert property (@(posedge clk) disable iff (rst)
        (locked && !va_rd) |=> ($stable(va_q) && $stable(stat_q) && $stable(form_q)));

    // Misspeculated faults leave every register as it was.
    assert_misspec_hold_R5: assert property (@(posedge clk) disable iff (rst)
        misspec |=> ($stable(va_q) && $stable(stat_q) && $stable(form_q)));

    // A read by itself never disturbs the captured contents.
    assert_read_keeps_R7: assert property (@(posedge clk) disable iff (rst)
        va_rd |=> ($stable(va_q) && $stable(stat_q) && $stable(form_q)));

    // The lock rising is accompanied by the faulting address appearing.
    assert_capture_va_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> (va_q == $past(fault_va)));

endmodule

// File: tb/test_fault_capture_regs.sv
module test_fault_capture_regs;

    localparam int CLK_PERIOD = 10;
    localparam int VA_W       = 64;

    logic              clk = 1'b0;
    logic              rst;
    logic              fault_stb;
    logic [VA_W-1:0]   fault_va;
    logic [5:0]        fault_opc;
    logic [4:0]        fault_dreg;
    logic [5:0]        fault_flags;
    logic [VA_W-1:0]   pt_base;
    logic              misspec;
    logic              va_rd;
    logic [VA_W-1:0]   va_q;
    logic [16:0]       stat_q;
    logic [VA_W-1:0]   form_q;
    logic              locked;

    always #(CLK_PERIOD/2) clk = ~clk;

    fault_capture_regs #(.VA_W(VA_W), .PAGE_SHIFT(13), .PTE_SHIFT(3)) i_fault_capture_regs (
        .clk         (clk),
        .rst         (rst),
        .fault_stb   (fault_stb),
        .fault_va    (fault_va),
        .fault_opc   (fault_opc),
        .fault_dreg  (fault_dreg),
        .fault_flags (fault_flags),
        .pt_base     (pt_base),
        .misspec     (misspec),
        .va_rd       (va_rd),
        .va_q        (va_q),
        .stat_q      (stat_q),
        .form_q      (form_q),
        .locked      (locked)
    );

    int n_cmp  = 0;
    int n_bad  = 0;
    bit done   = 1'b0;

    // Reference state
    logic [VA_W-1:0] m_va, m_form;
    logic [16:0]     m_stat;
    logic            m_lock;

    // Scoreboard queues
    logic [VA_W-1:0] q_va[$];
    logic [VA_W-1:0] q_form[$];
    logic [16:0]     q_stat[$];
    logic            q_lock[$];
    string           q_tag[$];

    task automatic compare(input string tag, input logic [VA_W-1:0] ev,
                           input logic [16:0] es, input logic [VA_W-1:0] ef,
                           input logic el);
        n_cmp++;
        if (va_q !== ev || stat_q !== es || form_q !== ef || locked !== el) begin
            n_bad++;
            $display("FAIL %s: va=%h stat=%h form=%h lock=%b expected va=%h stat=%h form=%h lock=%b",
                     tag, va_q, stat_q, form_q, locked, ev, es, ef, el);
        end
    endtask

    function automatic void push_exp(input string tag);
        q_va.push_back(m_va);
        q_stat.push_back(m_stat);
        q_form.push_back(m_form);
        q_lock.push_back(m_lock);
        q_tag.push_back(tag);
    endfunction

    // Driver: one cycle of stimulus, reference update, expectation pushed.
    task automatic step(input logic f, input logic [VA_W-1:0] va, input logic [5:0] op,
                        input logic [4:0] ra, input logic [5:0] fl, input logic [VA_W-1:0] base,
                        input logic ms, input logic rd, input string tag);
        logic cap;
        @(negedge clk);
        fault_stb   = f;
        fault_va    = va;
        fault_opc   = op;
        fault_dreg  = ra;
        fault_flags = fl;
        pt_base     = base;
        misspec     = ms;
        va_rd       = rd;
        cap = f && !ms && !m_lock && !rd;
        if (cap) begin
            m_va   = va;
            m_stat = (17'(op) << 11) | (17'(ra) << 6) | 17'(fl);
            m_form = base | ((va >> 13) << 3);
        end
        if (rd) m_lock = 1'b0;
        else if (cap) m_lock = 1'b1;
        push_exp(tag);
    endtask

    task automatic idle(input string tag);
        step(1'b0, '0, '0, '0, '0, '0, 1'b0, 1'b0, tag);
    endtask

    task automatic rd_only(input string tag);
        step(1'b0, '0, '0, '0, '0, '0, 1'b0, 1'b1, tag);
    endtask

    // Monitor: compares just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_tag.size() > 0) begin
                compare(q_tag.pop_front(), q_va.pop_front(), q_stat.pop_front(),
                        q_form.pop_front(), q_lock.pop_front());
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [VA_W-1:0] base;
        base = 64'h0000_0200_0000_0000;
        rst = 1'b1; fault_stb = 1'b0; fault_va = '0; fault_opc = '0; fault_dreg = '0;
        fault_flags = '0; pt_base = '0; misspec = 1'b0; va_rd = 1'b0;
        m_va = '0; m_stat = '0; m_form = '0; m_lock = 1'b0;
        repeat (3) @(negedge clk);
        compare("R9 reset state", '0, '0, '0, 1'b0);
        rst = 1'b0;

        // First capture from the open state
        step(1'b1, 64'h0000_0123_4567_89AB, 6'h2A, 5'h13, 6'b100001, base, 1'b0, 1'b0, "R3 capture");
        // Fault while locked is ignored
        step(1'b1, 64'h0000_0FFF_0000_1000, 6'h05, 5'h02, 6'b000010, base, 1'b0, 1'b0, "R6 locked fault");
        idle("R6 hold");
        // Read releases lock, keeps contents
        rd_only("R7 read unlock");
        // Read and fault together while open: no capture
        step(1'b1, 64'h0000_0000_DEAD_0000, 6'h11, 5'h07, 6'b010000, base, 1'b0, 1'b1, "R8 read+fault open");
        // Misspeculated fault
        step(1'b1, 64'h0000_0000_BEEF_0000, 6'h12, 5'h08, 6'b001000, base, 1'b1, 1'b0, "R5 misspec");
        idle("R5 after misspec");
        // All-ones fields
        step(1'b1, '1, 6'h3F, 5'h1F, 6'h3F, '0, 1'b0, 1'b0, "R1 all ones");
        // Read and fault together while locked
        step(1'b1, 64'h0000_0000_0000_4000, 6'h01, 5'h01, 6'h01, base, 1'b0, 1'b1, "R8 read+fault locked");
        idle("R8 after read");
        // Each flag bit in its own position
        for (int k = 0; k < 6; k++) begin
            step(1'b1, 64'h0000_0000_0010_0000 + 64'(k), 6'h00, 5'h00, 6'(1 << k), base, 1'b0, 1'b0, "R2 flag bit");
            rd_only("R7 read between flags");
        end
        // Opcode alone and register alone
        step(1'b1, 64'h0000_0000_0000_0000, 6'h01, 5'h00, 6'h00, '0, 1'b0, 1'b0, "R1 opcode lsb");
        rd_only("R7 read");
        step(1'b1, 64'h0000_0000_0000_0000, 6'h00, 5'h01, 6'h00, '0, 1'b0, 1'b0, "R1 register lsb");
        rd_only("R7 read");
        // Formatted address: 0x5 | (1 << 3) = 0xD
        step(1'b1, 64'h0000_0000_0000_2000, 6'h00, 5'h00, 6'h00, 64'h5, 1'b0, 1'b0, "R4 formatted address");
        // Formatted address with a large page number
        rd_only("R7 read");
        step(1'b1, 64'h8000_0000_0000_7FFF, 6'h00, 5'h00, 6'h00, 64'h0, 1'b0, 1'b0, "R4 high vpn");
        // Reset while locked
        @(negedge clk);
        rst = 1'b1; fault_stb = 1'b0; va_rd = 1'b0; misspec = 1'b0;
        m_va = '0; m_stat = '0; m_form = '0; m_lock = 1'b0;
        push_exp("R9 reset while locked");
        @(negedge clk);
        rst = 1'b0;
        idle("R9 after reset");
        repeat (3) @(negedge clk);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule